// File: doc/BRIEF.md
# Morse Key Symbol Classifier

This block turns the raw contact of a Morse key into a stream of symbol codes. The key line arrives with no timing relation to the system clock, so it is first retimed through a short flop chain. A small state machine then measures how long the retimed key stays down. It counts in units of a slow sample tick supplied by the surrounding logic, so the short and long thresholds scale with the tick period.

When the key is let go, the block reports what kind of press it was. A brief hold is reported as a dot and a sustained hold as a dash. The report is a 2-bit code that stays at the idle value at all other times. Letter assembly, gap timing and contact debouncing are handled elsewhere.

Top module: `morse_key_classifier`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, sym_o is 2'b00 (none) and the press machine is in its released state.
- R2: key_i reaches the press machine through two flip-flops. A level applied to key_i before clock edge n is first acted on by a tick at edge n+2.
- R3: The press machine and sym_o change only at clock edges where tick_i is high. With tick_i low, key activity of any length leaves sym_o unchanged.
- R4: While the retimed key stays high, successive ticks step the machine from released to first-short, to second-short, to long.
- R5: Once in long, the machine remains there for as long as the retimed key is high at each tick.
- R6: A tick that sees the key low while the machine is in first-short or second-short sets sym_o to 2'b01 (dot).
- R7: A tick that sees the key low while the machine is in long sets sym_o to 2'b10 (dash).
- R8: A non-idle sym_o holds until the next tick and returns to 2'b00 at that tick.
- R9: A tick that sees the key low while the machine is released leaves sym_o at 2'b00.
- R10: sym_o never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable; the machine advances only on cycles where it is high |
| key_i | input | 1 | Raw Morse key level, high while pressed, asynchronous |
| sym_o | output | 2 | Symbol code: 00 none, 01 dot, 10 dash |

## Verification
The checker watches the state and output relations on every cycle. It checks that nothing moves without a tick, that a release from a short state gives a dot and one from the long state a dash, that the long state holds while the key stays down, that any symbol clears at the next tick, and that the unused code 11 never appears. The two-flop retiming latency and the press-length thresholds seen end to end at the pins can only be shown by the bench scenarios. Those scenarios sweep press lengths across the dot and dash boundary under dense, sparse and absent ticks, and compare against a behavioural model on every clock.

// File: rtl/morse_pkg.sv
package morse_pkg;
  localparam int STATE_W = 3;
  localparam int SYM_W   = 2;

  // sparse encoding leaves unused codes that recover to released
  typedef enum logic [STATE_W-1:0] {
    ST_UP     = 3'b000,
    ST_SHORT0 = 3'b001,
    ST_SHORT1 = 3'b010,
    ST_LONG   = 3'b100
  } press_state_e;

  typedef enum logic [SYM_W-1:0] {
    SYM_NONE = 2'b00,
    SYM_DOT  = 2'b01,
    SYM_DASH = 2'b10
  } sym_e;
endpackage

// File: rtl/morse_sync.sv
module morse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/morse_press_fsm.sv
module morse_press_fsm
  import morse_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         key_i,
  output press_state_e state_o,
  output sym_e         sym_o
);
  press_state_e state_q, state_d;
  sym_e         sym_q, sym_d;

  always_comb begin
    state_d = state_q;
    sym_d   = sym_q;
    if (tick_i) begin
      sym_d = SYM_NONE;
      unique case (state_q)
        ST_UP:     state_d = key_i ? ST_SHORT0 : ST_UP;
        ST_SHORT0: begin
          state_d = key_i ? ST_SHORT1 : ST_UP;
          if (!key_i) sym_d = SYM_DOT;
        end
        ST_SHORT1: begin
          state_d = key_i ? ST_LONG : ST_UP;
          if (!key_i) sym_d = SYM_DOT;
        end
        ST_LONG: begin
          state_d = key_i ? ST_LONG : ST_UP;
          if (!key_i) sym_d = SYM_DASH;
        end
        default:   state_d = ST_UP;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_UP;
      sym_q   <= SYM_NONE;
    end else begin
      state_q <= state_d;
      sym_q   <= sym_d;
    end
  end

  assign state_o = state_q;
  assign sym_o   = sym_q;
endmodule

// File: rtl/morse_key_classifier.sv
module morse_key_classifier
  import morse_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             key_i,
  output logic [SYM_W-1:0] sym_o
);
  logic         key_s;
  press_state_e fsm_state;
  sym_e         fsm_sym;

  morse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (key_i),
    .q_o   (key_s)
  );

  morse_press_fsm u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .key_i  (key_s),
    .state_o(fsm_state),
    .sym_o  (fsm_sym)
  );

  assign sym_o = fsm_sym;
endmodule

// File: rtl/morse_key_classifier_chk.sv
module morse_key_classifier_chk
  import morse_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tick_i,
  input logic                key_s_i,
  input logic [STATE_W-1:0]  state_i,
  input logic [SYM_W-1:0]    sym_i
);
  logic in_short;
  assign in_short = (state_i == ST_SHORT0) || (state_i == ST_SHORT1);

  AST_STILL_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(sym_i) && $stable(state_i)); // R3

  AST_UP_TO_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && state_i == ST_UP && key_s_i |=> state_i == ST_SHORT0); // R4

  AST_LONG_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && state_i == ST_LONG && key_s_i |=> state_i == ST_LONG); // R5

  AST_SHORT_GIVES_DOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && in_short && !key_s_i |=> sym_i == SYM_DOT); // R6

  AST_LONG_GIVES_DASH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && state_i == ST_LONG && !key_s_i |=> sym_i == SYM_DASH); // R7

  AST_SYM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && sym_i != SYM_NONE |=> sym_i == SYM_NONE); // R8

  AST_UP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && state_i == ST_UP && !key_s_i |=> sym_i == SYM_NONE); // R9

  AST_NO_ILLEGAL_SYM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_i != 2'b11); // R10
endmodule

bind morse_key_classifier morse_key_classifier_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .key_s_i(key_s),
  .state_i(fsm_state),
  .sym_i  (sym_o)
);

// File: tb/morse_key_classifier_tb_top.sv
module morse_key_classifier_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       key;
  logic [1:0] sym;

  int    n_checks = 0;
  int    n_fails  = 0;
  int    cyc      = 0;
  int    tick_mode = 0; // 0 every cycle, 1 every 4th, 2 never
  string cur_tag  = "R1";

  // behavioural reference
  int m_k1, m_k2, m_held, m_exp;

  morse_key_classifier dut_i (
    .clk_i (clk),
    .rst_ni(rst_n),
    .tick_i(tick),
    .key_i (key),
    .sym_o (sym)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: sym_o=%0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_k1 = 0; m_k2 = 0; m_held = 0; m_exp = 0;
    end else begin
      if (tick) begin
        if (m_k2 != 0) begin
          m_exp  = 0;
          m_held = (m_held < 3) ? m_held + 1 : 3;
        end else begin
          m_exp  = (m_held == 0) ? 0 : (m_held >= 3 ? 2 : 1);
          m_held = 0;
        end
      end
      m_k2 = m_k1;
      m_k1 = key;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      check(sym == m_exp[1:0], cur_tag, int'(sym), m_exp);
      check(sym != 2'b11, "R10", int'(sym), 0);
    end
    case (tick_mode)
      0:       tick <= 1'b1;
      1:       tick <= (cyc % 4 == 0);
      default: tick <= 1'b0;
    endcase
    if (cyc > 100000) begin
      n_fails++;
      n_checks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic press(input int n_down, input int n_up);
    @(negedge clk); key <= 1'b1;
    repeat (n_down - 1) @(negedge clk);
    @(negedge clk); key <= 1'b0;
    repeat (n_up) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; key = 1'b0; tick = 1'b0;
    repeat (3) @(negedge clk);
    check(sym == 2'b00, "R1", int'(sym), 0);
    key <= 1'b1;
    @(negedge clk);
    check(sym == 2'b00, "R1", int'(sym), 0);
    key <= 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(sym == 2'b00, "R1", int'(sym), 0);

    cur_tag = "R9"; idle(10);
    cur_tag = "R2"; press(1, 8);
    cur_tag = "R6"; press(2, 8);
    cur_tag = "R4";
    for (int len = 1; len <= 5; len++) press(len, 6);
    cur_tag = "R7"; press(3, 8);
    cur_tag = "R5"; press(25, 8);
    cur_tag = "R8";
    tick_mode = 1;
    press(6, 12);
    press(14, 12);
    for (int len = 1; len <= 16; len += 3) press(len, 10);
    cur_tag = "R3";
    tick_mode = 2;
    press(20, 10);
    check(sym == 2'b00, "R3", int'(sym), 0);
    press(3, 5);
    tick_mode = 0;
    idle(6);
    check(sym == 2'b00, "R3", int'(sym), 0);
    cur_tag = "R9"; idle(10);

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule